// File: doc/BRIEF.md
# Sample Byte Fetch and Length Controller

This block keeps a one-byte sample buffer stocked for a downstream bit sequencer. It issues one memory read at a time through a request/acknowledge handshake, places the returned byte in the buffer, and offers that byte on a valid/ready stream. It tracks the current read address and the number of bytes still to fetch. When the count runs out it either starts the sample again or raises an interrupt flag.

Software controls the block through simple write strobes. One strobe sets the loop and interrupt-enable flags. One sets the start-address code and one sets the length code. The last is the channel enable register, and only bit 4 of its data matters. The `active` output reports whether bytes remain to be fetched. It does not report whether sound is still coming out: the sequencer can still be playing up to two bytes after `active` drops.

Back-pressure rules are as follows. The memory side holds `mem_req` and `mem_addr` steady until it sees `mem_ack`, and it takes `mem_rdata` in that same cycle. The sample side holds `smp_valid` and `smp_data` steady until `smp_ready`, and a byte is handed over on a clock edge where both are high.

Top module: `smpl_fetch_ctrl`

## Requirements
- R1: After reset, `mem_req`, `smp_valid`, `active` and `irq` are all 0.
- R2: A restart loads the read address with 0xC000 + 64 × (start code) and the byte count with 16 × (length code) + 1. For example, code 0x80 gives a first read at 0xE000, and length code 1 gives 17 bytes.
- R3: `mem_req` rises on the clock edge after a cycle in which no read is outstanding, the buffer is empty and the count is nonzero. It then holds, with a stable `mem_addr`, until `mem_ack`. The byte on `mem_rdata` in the acknowledge cycle is the one that gets buffered.
- R4: A buffered byte stays on `smp_data` with `smp_valid` high until it is taken with `smp_ready`. Nothing else empties the buffer, including disabling the channel.
- R5: Each counted fetch advances the address by one, and 0xFFFF is followed by 0x8000.
- R6: Each counted fetch lowers the count by one. `active` is 1 exactly while the count is nonzero, so it falls on the edge that completes the last fetch.
- R7: With the loop flag set, reaching a count of zero reloads the address and count from the start and length codes. `active` stays 1 and no interrupt is raised.
- R8: Reaching zero with looping off and the interrupt enabled sets `irq` on that edge. `irq` then stays set until any enable-register write, or until a control write with the interrupt enable bit at 0.
- R9: An enable write with bit 4 = 0 zeroes the count, so `active` is 0 on the next edge. A read already outstanding still completes and its byte is buffered, but that fetch moves neither the address nor the count.
- R10: An enable write with bit 4 = 1 restarts the sample when the count is zero and changes nothing when the count is nonzero.
- R11: With a one-byte sample, `active` is already 0 while the fetched byte is still waiting in the buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Control write strobe |
| cfg_loop | input | 1 | Loop flag written by `cfg_we` |
| cfg_irq_en | input | 1 | Interrupt enable written by `cfg_we` |
| adr_we | input | 1 | Start-address code write strobe |
| adr_val | input | 8 | Start-address code |
| len_we | input | 1 | Length code write strobe |
| len_val | input | 8 | Length code |
| en_we | input | 1 | Enable register write strobe |
| en_wdata | input | 8 | Enable register data; bit 4 is the channel enable |
| mem_req | output | 1 | Read request (valid) |
| mem_addr | output | 16 | Read address |
| mem_ack | input | 1 | Read acknowledge, with data |
| mem_rdata | input | 8 | Read data |
| smp_valid | output | 1 | Buffer holds a byte |
| smp_data | output | 8 | Buffered byte |
| smp_ready | input | 1 | Sequencer takes the byte |
| active | output | 1 | Bytes remain to be fetched |
| irq | output | 1 | End-of-sample interrupt flag |

## Verification
The assertions assume that the memory side raises `mem_ack` only while `mem_req` is high. They also assume that register strobes are single-cycle pulses driven between clock edges. The bench's memory responder acknowledges only a visible request, after a random wait of 0 to 3 cycles, and returns a byte computed from the address. The consumer raises `smp_ready` at random. Every register write is a one-cycle pulse placed at a falling edge, and a redundant mid-stream enable is issued only while at least two bytes remain.

// File: rtl/sf_pkg.sv
package sf_pkg;
  localparam int EN_BIT = 4;

  typedef enum logic [1:0] {
    EN_IDLE = 2'd0,
    EN_HALT = 2'd1,
    EN_KICK = 2'd2
  } en_op_e;

  typedef struct packed {
    logic loop;
    logic irq_en;
  } sf_cfg_t;
endpackage

// File: rtl/sf_rd_port.sv
module sf_rd_port #(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              buf_full,
  input  logic [CNT_W-1:0]  bytes_left,
  input  logic              halt,
  input  logic [ADDR_W-1:0] cur_addr,
  input  logic              mem_ack,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              fill,
  output logic              counted
);
  logic pend_q, stale_q;
  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q  <= 1'b0;
      stale_q <= 1'b0;
      addr_q  <= '0;
    end else if (pend_q && mem_ack) begin
      pend_q  <= 1'b0;
      stale_q <= 1'b0;
    end else if (pend_q) begin
      if (halt) stale_q <= 1'b1;
    end else if (!buf_full && (bytes_left != '0)) begin
      pend_q  <= 1'b1;
      addr_q  <= cur_addr;
      stale_q <= halt;
    end
  end

  assign mem_req  = pend_q;
  assign mem_addr = addr_q;
  assign fill     = pend_q & mem_ack;
  assign counted  = fill & ~stale_q;
endmodule

// File: rtl/sf_walker.sv
module sf_walker
  import sf_pkg::*;
#(
  parameter int              ADDR_W    = 16,
  parameter int              CNT_W     = 13,
  parameter logic [ADDR_W-1:0] WRAP_ADDR = 16'h8000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              counted,
  input  logic              loop_en,
  input  en_op_e            en_op,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [CNT_W-1:0]  start_len,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [CNT_W-1:0]  bytes_left,
  output logic              end_evt
);
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;

  always_comb begin
    addr_d  = addr_q;
    cnt_d   = cnt_q;
    end_evt = 1'b0;
    if (counted && (cnt_q != '0)) begin
      addr_d = (addr_q == '1) ? WRAP_ADDR : addr_q + 1'b1;
      if (cnt_q == CNT_W'(1)) begin
        if (loop_en) begin
          addr_d = start_addr;
          cnt_d  = start_len;
        end else begin
          cnt_d   = '0;
          end_evt = 1'b1;
        end
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
    if (en_op == EN_HALT) begin
      cnt_d = '0;
    end else if ((en_op == EN_KICK) && (cnt_d == '0)) begin
      addr_d = start_addr;
      cnt_d  = start_len;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= '0;
      cnt_q  <= '0;
    end else begin
      addr_q <= addr_d;
      cnt_q  <= cnt_d;
    end
  end

  assign cur_addr   = addr_q;
  assign bytes_left = cnt_q;
endmodule

// File: rtl/sf_byte_buf.sv
module sf_byte_buf #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fill,
  input  logic [DATA_W-1:0] fill_data,
  input  logic              take_rdy,
  output logic              valid,
  output logic [DATA_W-1:0] data
);
  logic              full_q;
  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else begin
      full_q <= fill | (full_q & ~take_rdy);
      if (fill) data_q <= fill_data;
    end
  end

  assign valid = full_q;
  assign data  = data_q;
endmodule

// File: rtl/smpl_fetch_ctrl.sv
module smpl_fetch_ctrl
  import sf_pkg::*;
#(
  parameter int                ADDR_W     = 16,
  parameter int                DATA_W     = 8,
  parameter int                REG_W      = 8,
  parameter int                ADDR_SHIFT = 6,
  parameter int                LEN_SHIFT  = 4,
  parameter logic [ADDR_W-1:0] BASE_ADDR  = 16'hC000,
  parameter logic [ADDR_W-1:0] WRAP_ADDR  = 16'h8000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_loop,
  input  logic              cfg_irq_en,
  input  logic              adr_we,
  input  logic [REG_W-1:0]  adr_val,
  input  logic              len_we,
  input  logic [REG_W-1:0]  len_val,
  input  logic              en_we,
  input  logic [7:0]        en_wdata,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              smp_valid,
  output logic [DATA_W-1:0] smp_data,
  input  logic              smp_ready,
  output logic              active,
  output logic              irq
);
  localparam int CNT_W = REG_W + LEN_SHIFT + 1;

  sf_cfg_t           cfg_q;
  logic [REG_W-1:0]  adr_q, len_q;
  logic              irq_q;
  logic [ADDR_W-1:0] start_addr, cur_addr;
  logic [CNT_W-1:0]  start_len, bytes_left;
  logic              fill, counted, end_evt, irq_en_eff;
  en_op_e            en_op;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q <= '0;
      adr_q <= '0;
      len_q <= '0;
    end else begin
      if (cfg_we) begin
        cfg_q.loop   <= cfg_loop;
        cfg_q.irq_en <= cfg_irq_en;
      end
      if (adr_we) adr_q <= adr_val;
      if (len_we) len_q <= len_val;
    end
  end

  assign start_addr = BASE_ADDR + (ADDR_W'(adr_q) << ADDR_SHIFT);
  assign start_len  = (CNT_W'(len_q) << LEN_SHIFT) + CNT_W'(1);

  always_comb begin
    if (!en_we)                en_op = EN_IDLE;
    else if (en_wdata[EN_BIT]) en_op = EN_KICK;
    else                       en_op = EN_HALT;
  end

  sf_rd_port #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_rd (
    .clk(clk), .rst_n(rst_n), .buf_full(smp_valid), .bytes_left(bytes_left),
    .halt(en_op == EN_HALT), .cur_addr(cur_addr), .mem_ack(mem_ack),
    .mem_req(mem_req), .mem_addr(mem_addr), .fill(fill), .counted(counted)
  );

  sf_walker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .WRAP_ADDR(WRAP_ADDR)) u_walk (
    .clk(clk), .rst_n(rst_n), .counted(counted), .loop_en(cfg_q.loop),
    .en_op(en_op), .start_addr(start_addr), .start_len(start_len),
    .cur_addr(cur_addr), .bytes_left(bytes_left), .end_evt(end_evt)
  );

  sf_byte_buf #(.DATA_W(DATA_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .fill(fill), .fill_data(mem_rdata),
    .take_rdy(smp_ready), .valid(smp_valid), .data(smp_data)
  );

  assign irq_en_eff = cfg_we ? cfg_irq_en : cfg_q.irq_en;

  always_ff @(posedge clk) begin
    if (!rst_n)                          irq_q <= 1'b0;
    else if (end_evt && irq_en_eff)      irq_q <= 1'b1;
    else if (en_we || (cfg_we && !cfg_irq_en)) irq_q <= 1'b0;
  end

  assign irq    = irq_q;
  assign active = (bytes_left != '0);
endmodule

// File: rtl/smpl_fetch_chk.sv
module smpl_fetch_chk #(
  parameter int                ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] WRAP_ADDR = 16'h8000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_we,
  input logic              cfg_irq_en,
  input logic              en_we,
  input logic [7:0]        en_wdata,
  input logic              mem_req,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_ack,
  input logic              smp_valid,
  input logic [7:0]        smp_data,
  input logic              smp_ready,
  input logic              active,
  input logic              irq
);
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr)); // R3
  AST_NO_REQ_WHILE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !smp_valid); // R3
  AST_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_req && !smp_valid && active |=> mem_req); // R3
  AST_SMP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid && !smp_ready |=> smp_valid && $stable(smp_data)); // R4
  AST_ADDR_SPACE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> mem_addr >= WRAP_ADDR); // R5
  AST_FALL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(active) |-> $past((mem_req && mem_ack) || (en_we && !en_wdata[4]))); // R6
  AST_IRQ_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    en_we && !(mem_req && mem_ack) |=> !irq); // R8
  AST_IRQ_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we && !cfg_irq_en |=> !irq); // R8
  AST_HALT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    en_we && !en_wdata[4] |=> !active); // R9
  AST_KICK_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    en_we && en_wdata[4] |=> active); // R10
endmodule

bind smpl_fetch_ctrl smpl_fetch_chk #(.ADDR_W(ADDR_W), .WRAP_ADDR(WRAP_ADDR)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_irq_en(cfg_irq_en),
  .en_we(en_we), .en_wdata(en_wdata), .mem_req(mem_req), .mem_addr(mem_addr),
  .mem_ack(mem_ack), .smp_valid(smp_valid), .smp_data(smp_data),
  .smp_ready(smp_ready), .active(active), .irq(irq)
);

// File: tb/smpl_fetch_ctrl_bench.sv
module smpl_fetch_ctrl_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 0, cfg_loop = 0, cfg_irq_en = 0, adr_we = 0, len_we = 0, en_we = 0;
  logic [7:0] adr_val = 0, len_val = 0, en_wdata = 0;
  logic mem_req, mem_ack = 0, smp_valid, smp_ready = 0, active, irq;
  logic [15:0] mem_addr;
  logic [7:0] mem_rdata = 0, smp_data;

  int checks = 0, errors = 0;
  bit done = 0, hold_ack = 0, cons_en = 0;
  int wait_ctr = 0;
  logic [15:0] aq[$];
  logic [7:0]  bq[$];

  always #5 clk = ~clk;

  smpl_fetch_ctrl u_smpl_fetch_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_loop(cfg_loop), .cfg_irq_en(cfg_irq_en),
    .adr_we(adr_we), .adr_val(adr_val), .len_we(len_we), .len_val(len_val),
    .en_we(en_we), .en_wdata(en_wdata), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .smp_valid(smp_valid), .smp_data(smp_data),
    .smp_ready(smp_ready), .active(active), .irq(irq)
  );

  function automatic logic [7:0] mem_byte(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h3C;
  endfunction

  function automatic logic [15:0] exp_addr(input logic [7:0] code, input int i);
    int x;
    x = 32'hC000 + int'(code) * 64 + i;
    if (x > 32'hFFFF) x = x - 32'h10000 + 32'h8000;
    return x[15:0];
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // memory responder and sample consumer, both driven between edges
  initial begin
    forever begin
      @(negedge clk);
      mem_ack = 0;
      if (mem_req && !hold_ack) begin
        if (wait_ctr == 0) begin
          mem_ack = 1;
          mem_rdata = mem_byte(mem_addr);
          aq.push_back(mem_addr);
          wait_ctr = $urandom % 4;
        end else wait_ctr--;
      end
      smp_ready = cons_en ? 1'($urandom % 2) : 1'b0;
      if (smp_valid && smp_ready) bq.push_back(smp_data);
    end
  end

  task automatic wr_en(input logic [7:0] d);
    @(negedge clk); en_we = 1; en_wdata = d;
    @(negedge clk); en_we = 0;
  endtask
  task automatic wr_cfg(input bit lp, input bit ie);
    @(negedge clk); cfg_we = 1; cfg_loop = lp; cfg_irq_en = ie;
    @(negedge clk); cfg_we = 0;
  endtask
  task automatic wr_code(input logic [7:0] a, input logic [7:0] l);
    @(negedge clk); adr_we = 1; adr_val = a; len_we = 1; len_val = l;
    @(negedge clk); adr_we = 0; len_we = 0;
  endtask
  task automatic drain();
    cons_en = 1; hold_ack = 0;
    wr_en(8'h00);
    for (int k = 0; k < 200; k++) begin
      @(negedge clk);
      if (!smp_valid && !mem_req) break;
    end
    repeat (3) @(negedge clk);
    #1;
    aq.delete(); bq.delete();
  endtask

  task automatic stream(input logic [7:0] a, input logic [7:0] l, input bit mid_kick);
    int len;
    bit kicked = 0;
    len = int'(l) * 16 + 1;
    cons_en = 1;
    wr_code(a, l);
    aq.delete(); bq.delete();
    wr_en(8'h10);
    for (int k = 0; k < 5000; k++) begin
      @(negedge clk); #1;
      if (aq.size() == len) break;
      if (mid_kick && !kicked && aq.size() >= 1 && aq.size() < len - 2) begin
        kicked = 1;
        wr_en(8'h10); // R10 redundant enable while bytes remain
      end
    end
    chk(active == 1, "R6 active before last fetch edge", active, 1);
    @(negedge clk); #1;
    chk(active == 0, "R6 active drops after last fetch", active, 0);
    for (int k = 0; k < 200; k++) begin
      @(negedge clk); #1;
      if (!smp_valid) break;
    end
    repeat (3) @(negedge clk);
    #1;
    chk(aq.size() == len, "R10 fetch total", aq.size(), len);
    chk(bq.size() == len, "R4 consumed total", bq.size(), len);
    for (int i = 0; i < len && i < aq.size() && i < bq.size(); i++) begin
      if (aq[i] !== exp_addr(a, i) || bq[i] !== mem_byte(exp_addr(a, i))) begin
        chk(0, "R5 address/data sequence", int'(aq[i]), int'(exp_addr(a, i)));
        break;
      end
    end
    checks++;
    aq.delete(); bq.delete();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    chk(!mem_req && !smp_valid && !active && !irq, "R1 reset state",
        {mem_req, smp_valid, active, irq}, 0);

    // R2 R3 R11 R8: one-byte sample at code 0x80
    wr_cfg(0, 1);
    wr_code(8'h80, 8'h00);
    hold_ack = 1;
    wr_en(8'h10);
    #1;
    chk(mem_req == 0 && active == 1, "R3 no request yet", mem_req, 0);
    @(negedge clk); #1;
    chk(mem_req == 1, "R3 request one edge later", mem_req, 1);
    chk(mem_addr == 16'hE000, "R2 start address", mem_addr, 16'hE000);
    repeat (3) @(negedge clk);
    #1;
    chk(mem_req == 1 && mem_addr == 16'hE000, "R3 request held", mem_addr, 16'hE000);
    hold_ack = 0; wait_ctr = 0;
    repeat (4) @(negedge clk);
    #1;
    chk(active == 0 && smp_valid == 1, "R11 idle with byte buffered", {active, smp_valid}, 1);
    chk(smp_data == mem_byte(16'hE000), "R3 buffered byte", smp_data, mem_byte(16'hE000));
    chk(irq == 1, "R8 irq on end", irq, 1);
    repeat (5) @(negedge clk);
    #1;
    chk(irq == 1 && smp_valid == 1, "R4 R8 held without ready", {irq, smp_valid}, 3);
    wr_en(8'h00);
    #1;
    chk(irq == 0, "R8 irq cleared by enable write", irq, 0);
    chk(smp_valid == 1, "R9 disable keeps buffer", smp_valid, 1);
    drain();

    // R8 cleared by control write
    wr_en(8'h10);
    repeat (6) @(negedge clk);
    #1;
    chk(irq == 1, "R8 irq set again", irq, 1);
    wr_cfg(0, 0);
    #1;
    chk(irq == 0, "R8 irq cleared by control", irq, 0);
    drain();

    // R7 loop with one-byte sample
    wr_cfg(1, 1);
    cons_en = 1;
    wr_en(8'h10);
    repeat (60) @(negedge clk);
    #1;
    chk(active == 1 && irq == 0, "R7 loop keeps active, no irq", {active, irq}, 2);
    chk(aq.size() >= 3, "R7 loop refetches", aq.size(), 3);
    foreach (aq[i]) if (aq[i] != 16'hE000) begin
      chk(0, "R7 loop address", aq[i], 16'hE000);
      break;
    end
    wr_en(8'h00);
    #1;
    chk(active == 0, "R9 disable zeroes count", active, 0);
    wr_cfg(0, 0);
    drain();

    // R9 R10 outstanding read at disable
    cons_en = 0;
    wr_code(8'h00, 8'h01);
    hold_ack = 1;
    wr_en(8'h10);
    @(negedge clk);
    wr_en(8'h00);
    #1;
    chk(active == 0 && mem_req == 1, "R9 read stays outstanding", {active, mem_req}, 1);
    hold_ack = 0; wait_ctr = 0;
    repeat (4) @(negedge clk);
    #1;
    chk(smp_valid == 1 && smp_data == mem_byte(16'hC000), "R9 late byte buffered",
        smp_data, mem_byte(16'hC000));
    chk(active == 0 && mem_req == 0, "R9 late fetch not counted", {active, mem_req}, 0);
    aq.delete();
    wr_en(8'h10);
    cons_en = 1;
    repeat (12) @(negedge clk);
    #1;
    chk(aq.size() > 0 && aq[0] == 16'hC000, "R10 restart from start",
        aq.size() > 0 ? aq[0] : 0, 16'hC000);
    drain();

    // R5 wrap, then random streams
    stream(8'hFF, 8'h05, 0);
    for (int t = 0; t < 6; t++)
      stream(8'($urandom % 256), 8'($urandom % 3), 1'($urandom % 2));

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule